// File: doc/BRIEF.md
# Telephony Codec Command Port Decoder

This block is the control-register side of a four-channel telephony codec. The host reaches it as an SPI slave in mode 0 (clock idles low, data sampled on the rising edge, MSB first), with 8-bit words. Every command is two bytes, and each byte normally sits in its own chip-select frame. The first byte is the mode byte. It names a register group and a channel, and it also carries configuration bits. The second byte is the data byte. The decoder applies the pair to one of three register groups:

- the channel-independent companding and frame-timing selections, together with per-channel path power and time-slot numbers;
- per-channel 14-bit gain coefficients, loaded 7 bits at a time;
- per-channel line-interface I/O directions and output levels.

A line-interface command also returns a status byte on MISO while its data byte is being shifted in. The SPI pins are oversampled by the block's own clock, which must run at least eight times faster than SCK. The SPI port has no flow control. It cannot refuse a byte, so there is no back-pressure. Every complete byte is consumed as it arrives. The register outputs are plain levels that are held until the next command that touches them.

Top module: `codec_cmd_port`

## Requirements
- R1: After reset, every path of every channel is powered down and all slot numbers are 0. mu-law (`alaw_sel`=0) and non-delayed timing (`delay_frame`=0) are selected. All gain coefficients are 0. I/O0 and I/O1 of every channel are inputs (`lif_dir_in` all ones), every output level is 0, and MISO is 0.
- R2: Bytes are received MSB first on rising SCK while CS is low. A command's effect appears on the register outputs within a few clock cycles after the eighth rising SCK edge of its data byte.
- R3: A mode byte whose bits 7:6 are `10` is a configuration command for the channel in bits 3:2. Its bit 5 (1 = A-law) and bit 4 (1 = delayed timing) update the shared selections, whatever the channel field holds.
- R4: In a configuration command, bit 0 powers up the receive path and loads the data byte into that channel's receive slot. Bit 1 does the same for the transmit path and slot. With both bits set, both paths are updated. A path whose bit is clear keeps its power and slot.
- R5: A configuration command with bits 1:0 both clear powers down both paths of that channel and leaves its slot numbers unchanged.
- R6: A mode byte of `1100 cc p h` is a gain command for channel cc. Path p is 0 = receive, 1 = transmit. Data bits 6:0 go to coefficient bits 6:0 when h=0, or to bits 13:7 when h=1. The other half and data bit 7 have no effect. No other command changes any gain.
- R7: A mode byte of `1101 cc d1 d0` is a line-interface command for channel cc. Each of d1 and d0 set to 1 makes I/O1 or I/O0 (respectively) an input. Data bits 4:0 set the output levels of I/O4..I/O0, and data bits 7:5 are ignored. I/O2..I/O4 are always outputs. No other command changes these registers.
- R8: After a line-interface mode byte, the next byte shifts out a status byte, MSB first, captured when the mode byte completed. Bits 7..3 hold the states of I/O0..I/O4 of the addressed channel. Bits 2, 1 and 0 hold the I/O0 state of channels 1, 2 and 3. An I/O's state is its pin level when it is an input, and its output level otherwise. For all other bytes, MISO shifts out zeros.
- R9: A frame that ends with 1 to 7 bits received discards any pending mode byte, and no register changes. The next complete byte is taken as a mode byte.
- R10: A mode byte outside the three groups (0x00-0x7F, 0xE0-0xFF) still consumes the following data byte, and no register changes.
- R11: Register outputs change only in the cycle after a complete command. MISO does not change while CS stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, at least 8x SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from host |
| spi_miso | output | 1 | SPI data to host |
| lif_pins | input | NCH*LIF_W | Pin levels of the line-interface I/Os, channel c at bits c*LIF_W+i |
| alaw_sel | output | 1 | 1 = A-law, 0 = mu-law |
| delay_frame | output | 1 | 1 = delayed frame timing |
| rx_pwr | output | NCH | Receive path powered, one bit per channel |
| tx_pwr | output | NCH | Transmit path powered, one bit per channel |
| rx_slot | output | NCH*SLOT_W | Receive slot numbers |
| tx_slot | output | NCH*SLOT_W | Transmit slot numbers |
| rx_gain | output | NCH*GAIN_W | Receive gain coefficients |
| tx_gain | output | NCH*GAIN_W | Transmit gain coefficients |
| lif_dir_in | output | NCH*2 | 1 = I/O0/I/O1 is an input, channel c at bits c*2+i |
| lif_out | output | NCH*LIF_W | Output levels of I/O0..I/O4 per channel |

## Verification
A pairing error in the command sequencer shifts every following command by one byte. The next snapshot then shows a mode byte written as data, or a register left stale, so the short-frame and unknown-mode tests each end with a full valid command whose outcome is compared. A misrouted channel or path index shows up at the register outputs within one command of the write. Each command is followed by a comparison of every register output, so a stray update on an untouched channel appears at once. A wrong status capture or a shift that is off by one shows only during the byte that follows a line-interface mode byte, so read-backs are taken on channels whose I/O0 and I/O1 are configured differently.

// File: rtl/codec_cmd_pkg.sv
package codec_cmd_pkg;
  localparam int BYTE_W       = 8;
  localparam int CH_FIELD_LSB = 2;
  localparam int CH_FIELD_W   = 2;
  localparam int FMT_ALAW_BIT = 5;
  localparam int FMT_DLY_BIT  = 4;
  localparam int PWR_TX_BIT   = 1;
  localparam int PWR_RX_BIT   = 0;
  localparam int GAIN_PATH_BIT = 1;
  localparam int GAIN_HALF_BIT = 0;
  localparam int DIR_FIELD_W  = 2;

  typedef enum logic [1:0] {
    GRP_NONE = 2'd0,
    GRP_CFG  = 2'd1,
    GRP_GAIN = 2'd2,
    GRP_LIF  = 2'd3
  } cmd_grp_e;

  typedef struct packed {
    logic [BYTE_W-1:0] mode;
    logic [BYTE_W-1:0] data;
  } cmd_pair_t;

  function automatic cmd_grp_e decode_grp(input logic [BYTE_W-1:0] m);
    if (m[7:6] == 2'b10)      return GRP_CFG;
    else if (m[7:4] == 4'hC)  return GRP_GAIN;
    else if (m[7:4] == 4'hD)  return GRP_LIF;
    else                      return GRP_NONE;
  endfunction
endpackage

// File: rtl/ccd_spi_link.sv
module ccd_spi_link #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  input  logic              load_en,
  input  logic [BYTE_W-1:0] load_byte,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic              short_frame,
  output logic              cs_idle,
  output logic              spi_miso
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] sck_p, cs_p, mosi_p;
  logic sck_s, cs_s, mosi_s, sck_q, cs_q;
  logic rise, fall, cs_end;
  logic [CNT_W-1:0] bit_cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh;

  assign sck_s  = sck_p[SYNC_STAGES-1];
  assign cs_s   = cs_p[SYNC_STAGES-1];
  assign mosi_s = mosi_p[SYNC_STAGES-1];
  assign rise   = sck_s & ~sck_q & ~cs_s;
  assign fall   = ~sck_s & sck_q & ~cs_s;
  assign cs_end = cs_s & ~cs_q;

  // pin synchronisers and edge history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p  <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sck_p  <= {sck_p[SYNC_STAGES-2:0], spi_sck};
      cs_p   <= {cs_p[SYNC_STAGES-2:0], spi_cs_n};
      mosi_p <= {mosi_p[SYNC_STAGES-2:0], spi_mosi};
      sck_q  <= sck_s;
      cs_q   <= cs_s;
    end
  end

  // receive side: bit counter, shift register, byte and short-frame strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt     <= '0;
      rx_sh       <= '0;
      byte_valid  <= 1'b0;
      byte_data   <= '0;
      short_frame <= 1'b0;
    end else begin
      byte_valid  <= rise && (bit_cnt == LAST_BIT);
      short_frame <= cs_end && (bit_cnt != '0);
      if (rise) begin
        rx_sh     <= {rx_sh[BYTE_W-2:0], mosi_s};
        byte_data <= {rx_sh[BYTE_W-2:0], mosi_s};
      end
      if (cs_s)
        bit_cnt <= '0;
      else if (rise)
        bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
    end
  end

  // transmit side: load wins, shift only on falling edges inside a byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tx_sh <= '0;
    else if (load_en)
      tx_sh <= load_byte;
    else if (fall && (bit_cnt != '0))
      tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
  end

  assign spi_miso = tx_sh[BYTE_W-1];
  assign cs_idle  = cs_s;
endmodule

// File: rtl/ccd_cmd_seq.sv
module ccd_cmd_seq
  import codec_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              short_frame,
  input  logic [BYTE_W-1:0] status_byte,
  output logic [CH_FIELD_W-1:0] status_ch,
  output logic              load_en,
  output logic [BYTE_W-1:0] load_byte,
  output logic              have_mode,
  output logic              cmd_valid,
  output cmd_pair_t         cmd
);
  logic [BYTE_W-1:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_mode <= 1'b0;
      mode_q    <= '0;
      cmd_valid <= 1'b0;
      cmd       <= '0;
    end else begin
      cmd_valid <= byte_valid && have_mode && !short_frame;
      if (byte_valid && have_mode)
        cmd <= '{mode: mode_q, data: byte_data};
      if (short_frame) begin
        have_mode <= 1'b0;
      end else if (byte_valid) begin
        have_mode <= !have_mode;
        if (!have_mode) mode_q <= byte_data;
      end
    end
  end

  // status is captured the moment a line-interface mode byte completes
  assign status_ch = byte_data[CH_FIELD_LSB +: CH_FIELD_W];
  assign load_en   = byte_valid;
  assign load_byte = (!have_mode && decode_grp(byte_data) == GRP_LIF) ? status_byte : '0;
endmodule

// File: rtl/ccd_reg_bank.sv
module ccd_reg_bank
  import codec_cmd_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int SLOT_W = 8,
  parameter int GAIN_W = 14,
  parameter int LIF_W  = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  cmd_pair_t              cmd,
  input  logic [NCH*LIF_W-1:0]   lif_pins,
  input  logic [CH_FIELD_W-1:0]  status_ch,
  output logic [BYTE_W-1:0]      status_byte,
  output logic                   alaw_sel,
  output logic                   delay_frame,
  output logic [NCH-1:0]         rx_pwr,
  output logic [NCH-1:0]         tx_pwr,
  output logic [NCH*SLOT_W-1:0]  rx_slot,
  output logic [NCH*SLOT_W-1:0]  tx_slot,
  output logic [NCH*GAIN_W-1:0]  rx_gain,
  output logic [NCH*GAIN_W-1:0]  tx_gain,
  output logic [NCH*DIR_FIELD_W-1:0] lif_dir_in,
  output logic [NCH*LIF_W-1:0]   lif_out
);
  localparam int HALF_W  = GAIN_W / 2;
  localparam int PEER_W  = BYTE_W - LIF_W;

  cmd_grp_e grp;
  logic [CH_FIELD_W-1:0] cmd_ch;
  assign grp    = decode_grp(cmd.mode);
  assign cmd_ch = cmd.mode[CH_FIELD_LSB +: CH_FIELD_W];

  wire [LIF_W-1:0] io_state [NCH];

  // shared format selections
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alaw_sel    <= 1'b0;
      delay_frame <= 1'b0;
    end else if (cmd_valid && grp == GRP_CFG) begin
      alaw_sel    <= cmd.mode[FMT_ALAW_BIT];
      delay_frame <= cmd.mode[FMT_DLY_BIT];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    logic rxp_q, txp_q;
    logic [SLOT_W-1:0] rxs_q, txs_q;
    logic [GAIN_W-1:0] rxg_q, txg_q;
    logic [DIR_FIELD_W-1:0] dir_q;
    logic [LIF_W-1:0] out_q;

    assign hit = cmd_valid && (int'(cmd_ch) == c);

    // power and slots
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rxp_q <= 1'b0;
        txp_q <= 1'b0;
        rxs_q <= '0;
        txs_q <= '0;
      end else if (hit && grp == GRP_CFG) begin
        if (!cmd.mode[PWR_RX_BIT] && !cmd.mode[PWR_TX_BIT]) begin
          rxp_q <= 1'b0;
          txp_q <= 1'b0;
        end else begin
          if (cmd.mode[PWR_RX_BIT]) begin
            rxp_q <= 1'b1;
            rxs_q <= cmd.data[SLOT_W-1:0];
          end
          if (cmd.mode[PWR_TX_BIT]) begin
            txp_q <= 1'b1;
            txs_q <= cmd.data[SLOT_W-1:0];
          end
        end
      end
    end

    // gain coefficient halves
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rxg_q <= '0;
        txg_q <= '0;
      end else if (hit && grp == GRP_GAIN) begin
        case ({cmd.mode[GAIN_PATH_BIT], cmd.mode[GAIN_HALF_BIT]})
          2'b00:   rxg_q[HALF_W-1:0]      <= cmd.data[HALF_W-1:0];
          2'b01:   rxg_q[GAIN_W-1:HALF_W] <= cmd.data[GAIN_W-HALF_W-1:0];
          2'b10:   txg_q[HALF_W-1:0]      <= cmd.data[HALF_W-1:0];
          default: txg_q[GAIN_W-1:HALF_W] <= cmd.data[GAIN_W-HALF_W-1:0];
        endcase
      end
    end

    // line-interface direction and levels
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dir_q <= '1;
        out_q <= '0;
      end else if (hit && grp == GRP_LIF) begin
        dir_q <= cmd.mode[DIR_FIELD_W-1:0];
        out_q <= cmd.data[LIF_W-1:0];
      end
    end

    for (genvar i = 0; i < LIF_W; i++) begin : g_io
      if (i < DIR_FIELD_W) begin : g_bidir
        assign io_state[c][i] = dir_q[i] ? lif_pins[c*LIF_W+i] : out_q[i];
      end else begin : g_outonly
        assign io_state[c][i] = out_q[i];
      end
    end

    assign rx_pwr[c] = rxp_q;
    assign tx_pwr[c] = txp_q;
    assign rx_slot[c*SLOT_W +: SLOT_W] = rxs_q;
    assign tx_slot[c*SLOT_W +: SLOT_W] = txs_q;
    assign rx_gain[c*GAIN_W +: GAIN_W] = rxg_q;
    assign tx_gain[c*GAIN_W +: GAIN_W] = txg_q;
    assign lif_dir_in[c*DIR_FIELD_W +: DIR_FIELD_W] = dir_q;
    assign lif_out[c*LIF_W +: LIF_W] = out_q;
  end

  // status byte: addressed channel reversed in the top bits, peer I/O0 below
  always_comb begin
    status_byte = '0;
    if (int'(status_ch) < NCH) begin
      for (int i = 0; i < LIF_W; i++)
        status_byte[BYTE_W-1-i] = io_state[status_ch][i];
    end
    for (int k = 0; k < PEER_W; k++) begin
      if (k + 1 < NCH)
        status_byte[PEER_W-1-k] = io_state[k+1][0];
    end
  end
endmodule

// File: rtl/codec_cmd_port.sv
module codec_cmd_port
  import codec_cmd_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int SLOT_W      = 8,
  parameter int GAIN_W      = 14,
  parameter int LIF_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   spi_sck,
  input  logic                   spi_cs_n,
  input  logic                   spi_mosi,
  output logic                   spi_miso,
  input  logic [NCH*LIF_W-1:0]   lif_pins,
  output logic                   alaw_sel,
  output logic                   delay_frame,
  output logic [NCH-1:0]         rx_pwr,
  output logic [NCH-1:0]         tx_pwr,
  output logic [NCH*SLOT_W-1:0]  rx_slot,
  output logic [NCH*SLOT_W-1:0]  tx_slot,
  output logic [NCH*GAIN_W-1:0]  rx_gain,
  output logic [NCH*GAIN_W-1:0]  tx_gain,
  output logic [NCH*2-1:0]       lif_dir_in,
  output logic [NCH*LIF_W-1:0]   lif_out
);
  logic              byte_valid, short_frame, cs_idle, load_en, have_mode, cmd_valid;
  logic [BYTE_W-1:0] byte_data, load_byte, status_byte;
  logic [CH_FIELD_W-1:0] status_ch;
  cmd_pair_t         cmd;

  ccd_spi_link #(.SYNC_STAGES(SYNC_STAGES), .BYTE_W(BYTE_W)) u_link (
    .clk(clk), .rst_n(rst_n),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .load_en(load_en), .load_byte(load_byte),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .short_frame(short_frame), .cs_idle(cs_idle), .spi_miso(spi_miso)
  );

  ccd_cmd_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .byte_valid(byte_valid), .byte_data(byte_data), .short_frame(short_frame),
    .status_byte(status_byte), .status_ch(status_ch),
    .load_en(load_en), .load_byte(load_byte),
    .have_mode(have_mode), .cmd_valid(cmd_valid), .cmd(cmd)
  );

  ccd_reg_bank #(.NCH(NCH), .SLOT_W(SLOT_W), .GAIN_W(GAIN_W), .LIF_W(LIF_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd(cmd), .lif_pins(lif_pins),
    .status_ch(status_ch), .status_byte(status_byte),
    .alaw_sel(alaw_sel), .delay_frame(delay_frame),
    .rx_pwr(rx_pwr), .tx_pwr(tx_pwr), .rx_slot(rx_slot), .tx_slot(tx_slot),
    .rx_gain(rx_gain), .tx_gain(tx_gain),
    .lif_dir_in(lif_dir_in), .lif_out(lif_out)
  );
endmodule

// File: rtl/codec_cmd_port_chk.sv
module codec_cmd_port_chk
  import codec_cmd_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int SLOT_W = 8,
  parameter int GAIN_W = 14,
  parameter int LIF_W  = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs_idle,
  input logic                  spi_miso,
  input logic                  cmd_valid,
  input cmd_pair_t             cmd,
  input logic                  short_frame,
  input logic                  have_mode,
  input logic                  alaw_sel,
  input logic                  delay_frame,
  input logic [NCH-1:0]        rx_pwr,
  input logic [NCH-1:0]        tx_pwr,
  input logic [NCH*SLOT_W-1:0] rx_slot,
  input logic [NCH*SLOT_W-1:0] tx_slot,
  input logic [NCH*GAIN_W-1:0] rx_gain,
  input logic [NCH*GAIN_W-1:0] tx_gain,
  input logic [NCH*2-1:0]      lif_dir_in,
  input logic [NCH*LIF_W-1:0]  lif_out
);
  cmd_grp_e grp;
  logic [CH_FIELD_W-1:0] ch_q;
  assign grp = decode_grp(cmd.mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ch_q <= '0;
    else if (cmd_valid) ch_q <= cmd.mode[CH_FIELD_LSB +: CH_FIELD_W];
  end

  // R11
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmd_valid) |-> $stable({alaw_sel, delay_frame, rx_pwr, tx_pwr, rx_slot, tx_slot}));

  // R11
  miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_idle && $past(cs_idle) && $past(cs_idle, 2)) |-> $stable(spi_miso));

  // R3
  shared_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && grp == GRP_CFG) |=>
      (alaw_sel == $past(cmd.mode[FMT_ALAW_BIT]) && delay_frame == $past(cmd.mode[FMT_DLY_BIT])));

  // R5
  pwr_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && grp == GRP_CFG && cmd.mode[1:0] == 2'b00 &&
     int'(cmd.mode[CH_FIELD_LSB +: CH_FIELD_W]) < NCH) |=> (!rx_pwr[ch_q] && !tx_pwr[ch_q]));

  // R6
  gain_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && grp != GRP_GAIN) |=> ($stable(rx_gain) && $stable(tx_gain)));

  // R7
  lif_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && grp != GRP_LIF) |=> ($stable(lif_out) && $stable(lif_dir_in)));

  // R9
  short_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    short_frame |=> !have_mode);
endmodule

bind codec_cmd_port codec_cmd_port_chk #(
  .NCH(NCH), .SLOT_W(SLOT_W), .GAIN_W(GAIN_W), .LIF_W(LIF_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .spi_miso(spi_miso),
  .cmd_valid(cmd_valid), .cmd(cmd), .short_frame(short_frame), .have_mode(have_mode),
  .alaw_sel(alaw_sel), .delay_frame(delay_frame),
  .rx_pwr(rx_pwr), .tx_pwr(tx_pwr), .rx_slot(rx_slot), .tx_slot(tx_slot),
  .rx_gain(rx_gain), .tx_gain(tx_gain), .lif_dir_in(lif_dir_in), .lif_out(lif_out)
);

// File: tb/codec_cmd_port_tb_top.sv
module codec_cmd_port_tb_top;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso;
  logic [NCH*5-1:0] lif_pins = '0;
  logic alaw_sel, delay_frame;
  logic [NCH-1:0] rx_pwr, tx_pwr;
  logic [NCH*8-1:0] rx_slot, tx_slot;
  logic [NCH*14-1:0] rx_gain, tx_gain;
  logic [NCH*2-1:0] lif_dir_in;
  logic [NCH*5-1:0] lif_out;

  always #5 clk = ~clk;

  codec_cmd_port dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .lif_pins(lif_pins), .alaw_sel(alaw_sel), .delay_frame(delay_frame),
    .rx_pwr(rx_pwr), .tx_pwr(tx_pwr), .rx_slot(rx_slot), .tx_slot(tx_slot),
    .rx_gain(rx_gain), .tx_gain(tx_gain), .lif_dir_in(lif_dir_in), .lif_out(lif_out)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model of the register state
  logic m_alaw, m_dly;
  logic [NCH-1:0] m_rxp, m_txp;
  logic [7:0] m_rxs [NCH];
  logic [7:0] m_txs [NCH];
  logic [13:0] m_rxg [NCH];
  logic [13:0] m_txg [NCH];
  logic [1:0] m_dir [NCH];
  logic [4:0] m_out [NCH];

  typedef struct {
    bit          is_read;
    string       tag;
    logic [7:0]  rd_exp;
    logic [7:0]  rd_act;
    logic [63:0] e_fmt, e_rxp, e_txp, e_rxs, e_txs, e_rxg, e_txg, e_dir, e_out;
  } exp_t;

  exp_t exp_q[$];
  event chk_ev;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_alaw = 0; m_dly = 0; m_rxp = '0; m_txp = '0;
    for (int c = 0; c < NCH; c++) begin
      m_rxs[c] = 0; m_txs[c] = 0; m_rxg[c] = 0; m_txg[c] = 0;
      m_dir[c] = 2'b11; m_out[c] = 0;
    end
  endtask

  task automatic model_apply(input logic [7:0] m, input logic [7:0] d);
    int c;
    c = int'(m[3:2]);
    if (m[7:6] == 2'b10) begin
      m_alaw = m[5]; m_dly = m[4];
      if (m[1:0] == 2'b00) begin
        m_rxp[c] = 0; m_txp[c] = 0;
      end else begin
        if (m[0]) begin m_rxp[c] = 1; m_rxs[c] = d; end
        if (m[1]) begin m_txp[c] = 1; m_txs[c] = d; end
      end
    end else if (m[7:4] == 4'hC) begin
      case (m[1:0])
        2'b00: m_rxg[c][6:0]  = d[6:0];
        2'b01: m_rxg[c][13:7] = d[6:0];
        2'b10: m_txg[c][6:0]  = d[6:0];
        default: m_txg[c][13:7] = d[6:0];
      endcase
    end else if (m[7:4] == 4'hD) begin
      m_dir[c] = m[1:0];
      m_out[c] = d[4:0];
    end
  endtask

  function automatic logic io_st(input int c, input int i);
    if (i < 2 && m_dir[c][i]) return lif_pins[c*5+i];
    return m_out[c][i];
  endfunction

  function automatic logic [7:0] exp_status(input int c);
    logic [7:0] s;
    s = '0;
    for (int i = 0; i < 5; i++) s[7-i] = io_st(c, i);
    for (int k = 0; k < 3; k++) s[2-k] = io_st(k + 1, 0);
    return s;
  endfunction

  task automatic push_snap(input string tag);
    exp_t e;
    e.is_read = 0; e.tag = tag; e.rd_exp = 0; e.rd_act = 0;
    e.e_fmt = {62'd0, m_alaw, m_dly};
    e.e_rxp = 64'(m_rxp); e.e_txp = 64'(m_txp);
    e.e_rxs = 0; e.e_txs = 0; e.e_rxg = 0; e.e_txg = 0; e.e_dir = 0; e.e_out = 0;
    for (int c = 0; c < NCH; c++) begin
      e.e_rxs[c*8 +: 8] = m_rxs[c];   e.e_txs[c*8 +: 8] = m_txs[c];
      e.e_rxg[c*14 +: 14] = m_rxg[c]; e.e_txg[c*14 +: 14] = m_txg[c];
      e.e_dir[c*2 +: 2] = m_dir[c];   e.e_out[c*5 +: 5] = m_out[c];
    end
    exp_q.push_back(e);
    -> chk_ev;
  endtask

  task automatic spi_frame(input logic [7:0] b, input int nbits, output logic [7:0] got);
    got = '0;
    spi_cs_n = 1'b0;
    #80;
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = b[7-i];
      #80;
      got[7-i] = spi_miso;
      spi_sck = 1'b1;
      #80;
      spi_sck = 1'b0;
    end
    #80;
    spi_cs_n = 1'b1;
    #160;
  endtask

  task automatic send_cmd(input logic [7:0] m, input logic [7:0] d, input string tag);
    logic [7:0] dummy;
    spi_frame(m, 8, dummy);
    spi_frame(d, 8, dummy);
    model_apply(m, d);
    push_snap(tag);
  endtask

  task automatic read_cmd(input logic [7:0] m, input logic [7:0] d, input string tag);
    exp_t e;
    logic [7:0] dummy, got;
    e.is_read = 1; e.tag = tag;
    e.rd_exp = exp_status(int'(m[3:2]));
    spi_frame(m, 8, dummy);
    spi_frame(d, 8, got);
    e.rd_act = got;
    exp_q.push_back(e);
    -> chk_ev;
    model_apply(m, d);
    push_snap(tag);
  endtask

  // monitor: pops expectations and compares against the outputs
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.is_read) begin
          chk(e.tag, "status", 64'(e.rd_act), 64'(e.rd_exp));
        end else begin
          chk(e.tag, "fmt", {62'd0, alaw_sel, delay_frame}, e.e_fmt);
          chk(e.tag, "rx_pwr", 64'(rx_pwr), e.e_rxp);
          chk(e.tag, "tx_pwr", 64'(tx_pwr), e.e_txp);
          chk(e.tag, "rx_slot", 64'(rx_slot), e.e_rxs);
          chk(e.tag, "tx_slot", 64'(tx_slot), e.e_txs);
          chk(e.tag, "rx_gain", 64'(rx_gain), e.e_rxg);
          chk(e.tag, "tx_gain", 64'(tx_gain), e.e_txg);
          chk(e.tag, "dir", 64'(lif_dir_in), e.e_dir);
          chk(e.tag, "out", 64'(lif_out), e.e_out);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] dummy;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    push_snap("R1");
    chk("R1", "miso", 64'(spi_miso), 64'd0);

    // R2 R4 receive path up on ch1, then transmit path keeps receive
    send_cmd(8'h85, 8'h05, "R2_R4");
    send_cmd(8'h86, 8'h09, "R4");
    // R3 R4 both paths of ch2 with A-law
    send_cmd(8'hAB, 8'h11, "R3_R4");
    // R3 R5 delay on a ch3 power-down, format shared from the latest write
    send_cmd(8'h9C, 8'h33, "R3_R5");
    // R5 ch1 powered down, slots kept
    send_cmd(8'h84, 8'h77, "R5");

    // R6 gain halves
    send_cmd(8'hC0, 8'h8B, "R6");
    send_cmd(8'hC1, 8'h14, "R6");
    send_cmd(8'hCF, 8'h7F, "R6");
    send_cmd(8'hCA, 8'h2A, "R6");

    // R7 line interface
    send_cmd(8'hD8, 8'hF5, "R7");
    send_cmd(8'hD5, 8'h0A, "R7");
    send_cmd(8'hDE, 8'hE0, "R7");

    // R8 read-back with mixed directions
    lif_pins = 20'hA5C3E;
    #160;
    read_cmd(8'hD5, 8'h1B, "R8");
    read_cmd(8'hD3, 8'h04, "R8");
    read_cmd(8'hDA, 8'h15, "R8");
    lif_pins = 20'h5A3C1;
    #160;
    read_cmd(8'hD2, 8'h00, "R8");

    // R9 short data frame discards the pending mode byte
    spi_frame(8'h85, 8, dummy);
    spi_frame(8'h3C, 4, dummy);
    push_snap("R9");
    send_cmd(8'h89, 8'h42, "R9");
    spi_frame(8'hC5, 5, dummy);
    send_cmd(8'hC4, 8'h55, "R9");

    // R10 unknown modes consume their data byte
    send_cmd(8'h55, 8'hFF, "R10");
    send_cmd(8'hE4, 8'h12, "R10");
    send_cmd(8'h8F, 8'h21, "R10");

    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule